// File: doc/BRIEF.md
# Buffered PWM Carrier Timer

This block produces the carrier count for a motor-control PWM stage. A 16-bit counter runs in one of three shapes: a symmetric triangle, an asymmetric triangle, or a sawtooth. A period compare register sets the top of the carrier. Three duty compare registers each raise a match pulse when the counter equals them. Downstream logic turns those pulses into gate drive, adds dead time, and handles interrupts.

Software writes shadow buffers at any time. The timer copies the buffers into the active compare registers only at carrier events that depend on the mode, so a duty or period change never splits a carrier cycle. While the timer is stopped, the active registers simply follow the buffers. The first carrier after a start therefore uses the values that were written beforehand.

The counter advances on a tick taken from a shared prescaler. The prescaler divides the system clock by 1, 2, 4, 8, 16 or 32.

Top module: `pwm_carrier_timer`

## Requirements
- R1: After reset, `count` is 0, `mode_q` is 00, `count_down` is 0, every active compare register is 0, and no pulse output is high.
- R2: While `enable` is low, the counter is held at 0 with `count_down` low. A cycle with `enable` low clears the counter on the next clock edge.
- R3: In modes 00 and 01, the counter counts up by one per tick until it equals the active period P. On that tick it holds its value and turns to count down. It then counts down by one per tick until it reaches 0. On the tick at 0 it holds its value and turns to count up. The resulting sequence is 0,1,…,P,P,P-1,…,0,0,1,…
- R4: In mode 10, the counter counts up by one per tick. On a tick where it equals the active period, it goes to 0 on the next edge.
- R5: `period_match` is high on a tick where the counter equals the active period. In modes 00 and 01 this also requires the counter to be counting up.
- R6: `underflow` is high on a tick where the counter is 0 and counting down. This applies only in modes 00 and 01.
- R7: In mode 00, the period and all three duty registers load from their buffers only on an `underflow` tick.
- R8: In mode 01, the period loads only on an `underflow` tick. The duty registers load on every `underflow` tick and on every `period_match` tick.
- R9: In mode 10, all four compare registers load from their buffers on a `period_match` tick.
- R10: `clk_sel` value k from 0 to 4 gives one tick every 2^k clocks. Values 5 to 7 give one tick every 32 clocks. The prescaler restarts from zero whenever `enable` is low, so the first tick after a start comes 2^k clocks after `enable` rises.
- R11: A mode write (`mode_wr` with `mode_wdata`) takes effect on the next edge only if `enable` is low in that cycle. Otherwise the write is ignored.
- R12: Mode 11 keeps the counter at 0 and produces no pulses, even with `enable` high.
- R13: While the counter is stopped, each active register takes its buffer value one cycle after the buffer holds it. While the counter runs, buffer writes (`buf_wr` bit i writes `buf_wdata` to buffer i; bits 0 to 2 are the duties and bit 3 is the period) leave the active registers unchanged except at the reload events of R7 to R9.
- R14: `duty_match[i]` is high on a tick where the counter equals active duty i, in any running mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; low clears and stops the counter |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode value: 00 symmetric triangle, 01 asymmetric triangle, 10 sawtooth, 11 stopped |
| clk_sel | input | 3 | Prescaler select |
| buf_wr | input | 4 | Buffer write strobes; bits 0 to 2 are duties, bit 3 is the period |
| buf_wdata | input | 16 | Buffer write data |
| mode_q | output | 2 | Current mode |
| count | output | 16 | Carrier counter |
| count_down | output | 1 | High while the counter is counting down |
| cmp_period | output | 16 | Active period compare |
| cmp_duty | output | 48 | Active duty compares; duty i is in bits 16i+15:16i |
| period_match | output | 1 | Period match pulse |
| underflow | output | 1 | Valley pulse in the triangle modes |
| duty_match | output | 3 | Per-duty match pulses |

## Verification
Directed runs drive each mode with small periods and prescaler ratios of 1, 2 and 8. They separate the dwell-at-turn triangle from the wrap-to-zero sawtooth, and they show that the valley pulse appears only when counting down. Buffer writes are placed in the middle of carriers and next to peaks and valleys. These show whether mode 00 ignores the peak, mode 01 reloads duties at both turns, and mode 10 reloads everything at the wrap. Corner runs use a period of zero in the triangle modes, mode 11, and mode writes attempted while enabled. A long seeded random run mixes starts and stops, prescaler changes and buffer writes, and compares every output against a cycle model in the bench on every clock.

// File: rtl/pwm_carrier_pkg.sv
package pwm_carrier_pkg;

  typedef enum logic [1:0] {
    MODE_TRI_SYM  = 2'b00,
    MODE_TRI_ASYM = 2'b01,
    MODE_SAW      = 2'b10,
    MODE_OFF      = 2'b11
  } carrier_mode_e;

  // number of prescaler taps; the slowest tap divides by 2**(PRESC_TAPS-1)
  localparam int unsigned PRESC_TAPS = 6;
  localparam int unsigned PRESC_W    = PRESC_TAPS - 1;

  // low bits of the prescaler that must all be set for a tick
  function automatic logic [PRESC_W-1:0] presc_mask(input logic [2:0] sel);
    logic [PRESC_W-1:0] m;
    if (int'(sel) >= int'(PRESC_W)) m = '1;
    else m = PRESC_W'((PRESC_W'(1) << sel) - PRESC_W'(1));
    return m;
  endfunction

  function automatic logic mode_runs(input carrier_mode_e m);
    return m != MODE_OFF;
  endfunction

  function automatic logic mode_updown(input carrier_mode_e m);
    return (m == MODE_TRI_SYM) || (m == MODE_TRI_ASYM);
  endfunction

  // reload event for the period register
  function automatic logic period_reload(input carrier_mode_e m,
                                         input logic peak, input logic valley);
    logic r;
    unique case (m)
      MODE_TRI_SYM, MODE_TRI_ASYM: r = valley;
      MODE_SAW:                    r = peak;
      default:                     r = 1'b0;
    endcase
    return r;
  endfunction

  // reload event for the duty registers
  function automatic logic duty_reload(input carrier_mode_e m,
                                       input logic peak, input logic valley);
    logic r;
    unique case (m)
      MODE_TRI_SYM:  r = valley;
      MODE_TRI_ASYM: r = valley | peak;
      MODE_SAW:      r = peak;
      default:       r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_carrier_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);

  logic [PRESC_W-1:0] pre_q;
  logic [PRESC_W-1:0] mask;

  assign mask = presc_mask(3'(clk_sel));
  assign tick = (pre_q & mask) == mask;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (!enable) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/pwm_carrier_counter.sv
module pwm_carrier_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step,
  input  logic             updown,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             count_down,
  output logic             peak_hit,
  output logic             valley_hit
);

  logic [CNT_W-1:0] cnt_q;
  logic             down_q;
  logic             at_period;
  logic             at_zero;

  assign at_period  = cnt_q == period;
  assign at_zero    = cnt_q == '0;
  assign peak_hit   = step && at_period && (!updown || !down_q);
  assign valley_hit = step && updown && down_q && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (step) begin
      if (updown) begin
        if (peak_hit)        down_q <= 1'b1;
        else if (valley_hit) down_q <= 1'b0;
        else if (down_q)     cnt_q  <= cnt_q - 1'b1;
        else                 cnt_q  <= cnt_q + 1'b1;
      end else begin
        down_q <= 1'b0;
        cnt_q  <= peak_hit ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign count      = cnt_q;
  assign count_down = down_q;

endmodule

// File: rtl/pwm_compare_bank.sv
module pwm_compare_bank #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_REG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     load_duty,
  input  logic                     load_period,
  input  logic [NUM_REG-1:0]       wr_en,
  input  logic [CNT_W-1:0]         wr_data,
  output logic [NUM_REG*CNT_W-1:0] act_flat
);

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    localparam bit IS_PERIOD = (g == NUM_REG - 1);
    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] act_q;
    logic             load;

    assign load = !run || (IS_PERIOD ? load_period : load_duty);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_en[g]) buf_q <= wr_data;
        if (load)     act_q <= buf_q;
      end
    end

    assign act_flat[g*CNT_W +: CNT_W] = act_q;
  end

endmodule

// File: rtl/pwm_carrier_timer.sv
module pwm_carrier_timer
  import pwm_carrier_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_DUTY = 3,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      mode_wr,
  input  logic [1:0]                mode_wdata,
  input  logic [SEL_W-1:0]          clk_sel,
  input  logic [NUM_DUTY:0]         buf_wr,
  input  logic [CNT_W-1:0]          buf_wdata,
  output logic [1:0]                mode_q,
  output logic [CNT_W-1:0]          count,
  output logic                      count_down,
  output logic [CNT_W-1:0]          cmp_period,
  output logic [NUM_DUTY*CNT_W-1:0] cmp_duty,
  output logic                      period_match,
  output logic                      underflow,
  output logic [NUM_DUTY-1:0]       duty_match
);

  localparam int unsigned NUM_REG = NUM_DUTY + 1;

  carrier_mode_e        mode_r;
  logic                 run;
  logic                 tick;
  logic                 step;
  logic                 updown;
  logic                 peak_hit;
  logic                 valley_hit;
  logic                 load_duty;
  logic                 load_period;
  logic [NUM_REG*CNT_W-1:0] act_flat;

  // mode register: writable only while stopped
  always_ff @(posedge clk) begin
    if (!rst_n)                  mode_r <= MODE_TRI_SYM;
    else if (mode_wr && !enable) mode_r <= carrier_mode_e'(mode_wdata);
  end

  assign run    = enable && mode_runs(mode_r);
  assign updown = mode_updown(mode_r);
  assign step   = run && tick;

  pwm_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .clk_sel (clk_sel),
    .tick    (tick)
  );

  pwm_carrier_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .step       (step),
    .updown     (updown),
    .period     (cmp_period),
    .count      (count),
    .count_down (count_down),
    .peak_hit   (peak_hit),
    .valley_hit (valley_hit)
  );

  assign load_duty   = duty_reload(mode_r, peak_hit, valley_hit);
  assign load_period = period_reload(mode_r, peak_hit, valley_hit);

  pwm_compare_bank #(.CNT_W(CNT_W), .NUM_REG(NUM_REG)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .load_duty   (load_duty),
    .load_period (load_period),
    .wr_en       (buf_wr),
    .wr_data     (buf_wdata),
    .act_flat    (act_flat)
  );

  assign cmp_period = act_flat[NUM_DUTY*CNT_W +: CNT_W];
  assign cmp_duty   = act_flat[NUM_DUTY*CNT_W-1:0];

  for (genvar d = 0; d < NUM_DUTY; d++) begin : g_match
    assign duty_match[d] = step && (count == cmp_duty[d*CNT_W +: CNT_W]);
  end

  assign period_match = peak_hit;
  assign underflow    = valley_hit;
  assign mode_q       = mode_r;

endmodule

// File: rtl/pwm_carrier_timer_chk.sv
module pwm_carrier_timer_chk #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_DUTY = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      enable,
  input logic                      run,
  input logic [1:0]                mode_q,
  input logic [CNT_W-1:0]          count,
  input logic                      count_down,
  input logic [CNT_W-1:0]          cmp_period,
  input logic [NUM_DUTY*CNT_W-1:0] cmp_duty,
  input logic                      period_match,
  input logic                      underflow
);

  a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0 && !count_down));

  a_r3_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (count <= cmp_period));

  a_r3_peak_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && mode_q != 2'b10) |=> ($stable(count) && count_down));

  a_r4_saw_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && mode_q == 2'b10) |=> (count == '0));

  a_r5_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(period_match && underflow));

  a_r6_valley_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (count == '0 && count_down && mode_q != 2'b10));

  a_r7_sym_peak_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && mode_q == 2'b00) |=> ($stable(cmp_duty) && $stable(cmp_period)));

  a_r8_asym_peak_period_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (period_match && mode_q == 2'b01) |=> $stable(cmp_period));

  a_r11_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(mode_q));

  a_r12_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11) |-> (!period_match && !underflow && count == '0));

  a_r13_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !period_match && !underflow) |=> ($stable(cmp_period) && $stable(cmp_duty)));

endmodule

bind pwm_carrier_timer pwm_carrier_timer_chk #(.CNT_W(CNT_W), .NUM_DUTY(NUM_DUTY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .run          (run),
  .mode_q       (mode_q),
  .count        (count),
  .count_down   (count_down),
  .cmp_period   (cmp_period),
  .cmp_duty     (cmp_duty),
  .period_match (period_match),
  .underflow    (underflow)
);

// File: tb/pwm_carrier_timer_bench.sv
`timescale 1ns/100ps
module pwm_carrier_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_wdata = 2'b00;
  logic [2:0]  clk_sel = 3'd0;
  logic [3:0]  buf_wr = 4'd0;
  logic [15:0] buf_wdata = 16'd0;
  logic [1:0]  mode_q;
  logic [15:0] count;
  logic        count_down;
  logic [15:0] cmp_period;
  logic [47:0] cmp_duty;
  logic        period_match;
  logic        underflow;
  logic [2:0]  duty_match;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // bench reference state
  int m_cnt = 0, m_pre = 0, m_mode = 0;
  bit m_down = 0;
  int m_buf[4] = '{0, 0, 0, 0};
  int m_act[4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  pwm_carrier_timer u_pwm_carrier_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .clk_sel(clk_sel), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .mode_q(mode_q), .count(count),
    .count_down(count_down), .cmp_period(cmp_period), .cmp_duty(cmp_duty),
    .period_match(period_match), .underflow(underflow), .duty_match(duty_match)
  );

  task automatic chk(string tag, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic int divide_of(int s);
    return (s > 4) ? 32 : (1 << s);
  endfunction

  function automatic bit duty_loads(int mode, bit pk, bit vl);
    case (mode)
      0: return vl;
      1: return pk || vl;
      2: return pk;
      default: return 0;
    endcase
  endfunction

  function automatic bit period_loads(int mode, bit pk, bit vl);
    if (mode == 2) return pk;
    if (mode == 3) return 0;
    return vl;
  endfunction

  // compare outputs against the model, then advance the model one clock
  task automatic cycle();
    bit run, stp, saw, e_pk, e_vl;
    string ctag, atag;
    #1;
    run  = enable && (m_mode != 3);
    stp  = run && ((m_pre % divide_of(int'(clk_sel))) == divide_of(int'(clk_sel)) - 1);
    saw  = (m_mode == 2);
    e_pk = stp && (m_cnt == m_act[3]) && (saw || !m_down);
    e_vl = stp && !saw && m_down && (m_cnt == 0);
    ctag = !enable ? "R2" : (m_mode == 3) ? "R12" : saw ? "R4" : "R3";
    atag = !run ? "R13" : (m_mode == 0) ? "R7" : (m_mode == 1) ? "R8" : "R9";
    chk(ctag, "count", int'(count), m_cnt);
    chk(ctag, "count_down", int'(count_down), int'(m_down));
    chk(atag, "cmp_period", int'(cmp_period), m_act[3]);
    for (int k = 0; k < 3; k++)
      chk(atag, "cmp_duty", int'(cmp_duty[16*k +: 16]), m_act[k]);
    chk("R5", "period_match", int'(period_match), int'(e_pk));
    chk("R6", "underflow", int'(underflow), int'(e_vl));
    for (int k = 0; k < 3; k++)
      chk("R14", "duty_match", int'(duty_match[k]), int'(stp && (m_cnt == m_act[k])));
    chk("R11", "mode_q", int'(mode_q), m_mode);
    // advance
    if (!run) begin
      for (int k = 0; k < 4; k++) m_act[k] = m_buf[k];
    end else begin
      if (period_loads(m_mode, e_pk, e_vl)) m_act[3] = m_buf[3];
      if (duty_loads(m_mode, e_pk, e_vl))
        for (int k = 0; k < 3; k++) m_act[k] = m_buf[k];
    end
    for (int k = 0; k < 4; k++) if (buf_wr[k]) m_buf[k] = int'(buf_wdata);
    if (mode_wr && !enable) m_mode = int'(mode_wdata);
    if (!enable) begin
      m_cnt = 0; m_down = 0;
    end else if (stp) begin
      if (saw) m_cnt = e_pk ? 0 : (m_cnt + 1) & 16'hffff;
      else if (e_pk) m_down = 1;
      else if (e_vl) m_down = 0;
      else m_cnt = m_down ? m_cnt - 1 : m_cnt + 1;
    end
    m_pre = enable ? (m_pre + 1) % 32 : 0;
    @(posedge clk);
    @(negedge clk);
    buf_wr  = 4'd0;
    mode_wr = 1'b0;
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr_buf(int idx, int val);
    buf_wr = 4'(1 << idx);
    buf_wdata = 16'(val);
    cycle();
  endtask

  task automatic set_mode(int m);
    mode_wr = 1'b1;
    mode_wdata = 2'(m);
    cycle();
  endtask

  task automatic load_all(int per, int d0, int d1, int d2);
    wr_buf(3, per); wr_buf(0, d0); wr_buf(1, d1); wr_buf(2, d2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, checked while still in reset
    chk("R1", "count", int'(count), 0);
    chk("R1", "mode_q", int'(mode_q), 0);
    chk("R1", "count_down", int'(count_down), 0);
    chk("R1", "cmp_period", int'(cmp_period), 0);
    chk("R1", "cmp_duty", int'(cmp_duty), 0);
    chk("R1", "pulses", int'({period_match, underflow, duty_match}), 0);
    rst_n = 1'b1;
    run_n(2);

    // sawtooth, period 5
    load_all(5, 1, 3, 5);
    set_mode(2);
    run_n(2);
    enable = 1'b1;
    run_n(10);
    wr_buf(3, 3); wr_buf(1, 0);
    run_n(20);
    // R11: mode write while running is ignored
    set_mode(0);
    chk("R11", "mode locked", int'(mode_q), 2);
    run_n(3);

    // symmetric triangle, divide by 2
    enable = 1'b0;
    clk_sel = 3'd1;
    load_all(4, 0, 2, 4);
    set_mode(0);
    run_n(2);
    enable = 1'b1;
    run_n(15);
    wr_buf(0, 3); wr_buf(3, 6);
    run_n(45);

    // asymmetric triangle, divide by 1
    enable = 1'b0;
    clk_sel = 3'd0;
    load_all(3, 1, 2, 3);
    set_mode(1);
    run_n(2);
    enable = 1'b1;
    run_n(5);
    wr_buf(2, 1); wr_buf(0, 2);
    run_n(20);

    // period 0 in a triangle mode
    enable = 1'b0;
    load_all(0, 0, 0, 0);
    run_n(2);
    enable = 1'b1;
    run_n(10);

    // R12: mode 11 stays stopped
    enable = 1'b0;
    set_mode(3);
    load_all(4, 1, 1, 1);
    enable = 1'b1;
    run_n(10);
    chk("R12", "count stays zero", int'(count), 0);

    // R10: divide by 8, two ticks in 16 clocks after start
    enable = 1'b0;
    set_mode(2);
    load_all(100, 50, 60, 70);
    clk_sel = 3'd3;
    run_n(2);
    enable = 1'b1;
    run_n(16);
    chk("R10", "count after 16 clocks at /8", int'(count), 2);
    // R2: stop clears
    enable = 1'b0;
    run_n(1);
    chk("R2", "count cleared", int'(count), 0);

    // seeded random mix
    clk_sel = 3'd0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 4 == 0) begin
        buf_wr = 4'($urandom);
        buf_wdata = 16'($urandom % 20);
      end
      if ($urandom % 8 == 0) begin
        mode_wr = 1'b1;
        mode_wdata = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      end
      if ($urandom % 150 == 0) begin
        enable = ~enable;
        if (!enable) clk_sel = 3'($urandom % 8);
      end
      cycle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule